// File: doc/BRIEF.md
# Half-Rate Enable-Framed Serial Transmitter

This block shifts a short control word into a peripheral over two wires: an active-low enable and a serial data line. The peripheral is fed the continuous system clock and divides it by two on its own. That half-rate clock starts low. Its first rising edge falls on the first system-clock falling edge after a rising edge at which the enable was seen low. From then on it toggles on every falling edge, and the peripheral takes one data bit on each of its rising edges. The transmitter never sees that divided clock. It therefore places the enable, every bit and the release on system-clock falling edges so that they line up with the hidden phase.

A one-cycle start pulse presents a word and begins a transfer. The word goes out most significant bit first, and each bit is held for two system-clock periods centred on its sampling edge. The enable stays low for one more period after the last bit is taken. It is then released on a falling edge, before the next rising edge, so the peripheral sees exactly one transfer. Busy covers the whole transfer, and done pulses once when it ends. Choosing which words to send, and when, is left to the logic around the block.

Top module: `hr_frame_tx`

## Requirements
- R1: After reset, and whenever no transfer is running, enable_n_o is 1, sdata_o is 0, busy_o is 0 and done_o is 0. A start_i that is high while reset is held has no effect.
- R2: A start_i that is high at a rising edge while busy_o is 0 is accepted, and busy_o is 1 after that edge. busy_o stays 1 through the rising edge at which the enable is first seen high again.
- R3: enable_n_o goes low on the first falling edge after the rising edge that accepted the start. It is still high when sampled just after that rising edge.
- R4: Bit k of the transfer (k = 0 is word_i[W-1], the MSB; the last is word_i[0]) is on sdata_o from falling edge 2k to falling edge 2k+2, where falling edge 0 is the one that lowers the enable. Each bit therefore spans the half-rate rising edge at falling edge 2k+1.
- R5: enable_n_o is seen low at exactly 2*W consecutive rising edges (14 for W = 7). It then returns to 1, and sdata_o to 0, on the falling edge after the last of those rising edges.
- R6: done_o is 1 for exactly one cycle, after the first rising edge at which the enable is seen high again. busy_o is 0 in that same cycle.
- R7: A start_i that is high while busy_o is 1 is ignored: the word in flight and its timing are unchanged, and no extra transfer follows. Changes on word_i during a transfer also have no effect.
- R8: A receiver built from the system clock and the enable, as described above, takes every accepted word with all W bits correct, and counts exactly one transfer per accepted start.
- R9: A start in the cycle in which done_o is 1 is accepted. The enable is still seen high at one rising edge between the two transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also fed to the peripheral |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to send word_i |
| word_i | input | W | Word to send, MSB first |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse when a transfer has finished |
| enable_n_o | output | 1 | Active-low transfer enable to the peripheral |
| sdata_o | output | 1 | Serial data to the peripheral |

## Verification
A wrong tick count or state shows up at the ports within one system-clock period. The enable would drop or rise on the wrong falling edge, which shifts the data by a half-rate cycle or opens a second transfer. The behavioural receiver then reports a wrong word or an extra transfer when that transfer ends. A shift register that loses its place corrupts sdata_o on the very next bit slot, and the bench checks every bit slot by itself, right after each rising edge.

// File: rtl/hr_frame_tx_pkg.sv
// Shared types for the half-rate framed serial transmitter.
package hr_frame_tx_pkg;

    // Sequencer states: waiting, shifting bits out, releasing the enable.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_FINISH = 2'd2
    } tx_state_e;

endpackage

// File: rtl/hr_frame_tx_seq.sv
// Sequencer for the framed transmitter.
// Counts system-clock rising edges through one transfer of W bits
// (two ticks per bit) and tells the output stage when to drive.
// Assumes start_i is synchronous to clk. Starts are accepted only in idle.
module hr_frame_tx_seq
    import hr_frame_tx_pkg::*;
#(
    parameter int W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic shift_o,
    output logic drive_o,
    output logic busy_o,
    output logic done_o
);
    localparam int TICKS = 2 * W;
    localparam int CNT_W = $clog2(TICKS + 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(TICKS - 1);

    tx_state_e        state_q;
    logic [CNT_W-1:0] tick_q;

    // Accept a start only when fully idle.
    assign load_o  = (state_q == ST_IDLE) && start_i;
    // Advance to the next bit after the second tick of each bit slot.
    assign shift_o = (state_q == ST_SEND) && tick_q[0];
    assign drive_o = (state_q == ST_SEND);
    assign busy_o  = (state_q != ST_IDLE);

    // State and tick counter progression through one transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tick_q  <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_SEND;
                        tick_q  <= '0;
                    end
                end
                ST_SEND: begin
                    if (tick_q == LAST_TICK) begin
                        state_q <= ST_FINISH;
                    end
                    tick_q <= tick_q + 1'b1;
                end
                ST_FINISH: begin
                    state_q <= ST_IDLE;
                    done_o  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hr_frame_tx_shreg.sv
// Word holder and MSB-first shifter.
// Captures the word on load and shifts left on each shift request.
// Assumes load and shift never coincide (the sequencer guarantees it).
module hr_frame_tx_shreg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] word_i,
    output logic         msb_o
);
    logic [W-1:0] word_q;

    assign msb_o = word_q[W-1];

    // Load a new word, or move the next bit into the MSB position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load_i) begin
            word_q <= word_i;
        end else if (shift_i) begin
            word_q <= {word_q[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/hr_frame_tx_drv.sv
// Falling-edge output stage.
// Registers the enable and data on system-clock falling edges. This sets up
// the enable half a period ahead of the rising edge at which the peripheral
// sees it, and keeps each bit stable across the half-rate sampling edge.
// Assumes drive_i and bit_i come from rising-edge logic.
module hr_frame_tx_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_i,
    input  logic bit_i,
    output logic enable_n_o,
    output logic sdata_o
);
    // Drive enable low and present the data bit while a transfer runs.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            enable_n_o <= 1'b1;
            sdata_o    <= 1'b0;
        end else begin
            enable_n_o <= !drive_i;
            sdata_o    <= drive_i && bit_i;
        end
    end

endmodule

// File: rtl/hr_frame_tx.sv
// Half-rate enable-framed serial transmitter (top).
// Sends a W-bit word MSB first to a peripheral that divides the system clock
// by two internally. Assumes the peripheral samples the enable on rising
// edges and its half-rate clock starts on the following falling edge.
module hr_frame_tx #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] word_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         enable_n_o,
    output logic         sdata_o
);
    logic load, shift, drive, msb;

    hr_frame_tx_seq #(.W(W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .shift_o (shift),
        .drive_o (drive),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    hr_frame_tx_shreg #(.W(W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .word_i  (word_i),
        .msb_o   (msb)
    );

    hr_frame_tx_drv u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .drive_i    (drive),
        .bit_i      (msb),
        .enable_n_o (enable_n_o),
        .sdata_o    (sdata_o)
    );

endmodule

// File: rtl/hr_frame_tx_chk.sv
// Port-level checker for hr_frame_tx, attached with bind.
// Counts the rising edges at which the enable is seen low, so that the
// frame length is checked without deep $past windows.
module hr_frame_tx_chk #(
    parameter int W = 7
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic enable_n_o,
    input logic sdata_o
);
    localparam int FRAME = 2 * W;
    localparam int LC_W  = $clog2(FRAME + 2);

    logic [LC_W-1:0] low_cnt;

    // Length of the current run of low enable samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!enable_n_o) begin
            low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (enable_n_o && !sdata_o));

    assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    assert_frame_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_n_o && low_cnt != '0) |-> (low_cnt == LC_W'(FRAME)));

    assert_data_low_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        enable_n_o |-> !sdata_o);

    assert_done_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

bind hr_frame_tx hr_frame_tx_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .enable_n_o (enable_n_o),
    .sdata_o    (sdata_o)
);

// File: tb/hr_frame_tx_tb.sv
// Bench for hr_frame_tx: directed corners plus seeded random transfers,
// with a behavioural divide-by-two receiver on the serial pins.
module hr_frame_tx_tb;
    localparam int W = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] word_i = '0;
    logic         busy_o, done_o, enable_n_o, sdata_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [W-1:0] exp_words [0:255];
    int tx_count = 0;
    int rx_count = 0;

    always #4 clk = ~clk;

    hr_frame_tx #(.W(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .word_i     (word_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .enable_n_o (enable_n_o),
        .sdata_o    (sdata_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Bit expected on the data line during tick k of a transfer of word w.
    function automatic logic exp_bit(input logic [W-1:0] w, input int k);
        return w[W-1-(k/2)];
    endfunction

    // Behavioural receiver: half-rate clock built from clk and the enable.
    bit           rx_active = 1'b0;
    bit           rx_hc = 1'b0;
    int           rx_bits = 0;
    logic [W-1:0] rx_shift = '0;

    always @(posedge clk) begin
        if (rst_n && !rx_active && enable_n_o === 1'b0) begin
            rx_active = 1'b1;
            rx_hc     = 1'b0;
            rx_bits   = 0;
            rx_shift  = '0;
        end else if (rx_active && enable_n_o !== 1'b0) begin
            chk(1'b0, "R8 enable released early", {31'd0, enable_n_o}, 32'd0);
            rx_active = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rx_active) begin
            rx_hc = !rx_hc;
            if (rx_hc) begin
                rx_shift = {rx_shift[W-2:0], sdata_o};
                rx_bits++;
            end else if (rx_bits == W) begin
                rx_active = 1'b0;
                chk(rx_count < tx_count, "R8 extra transfer", rx_count, tx_count);
                if (rx_count < tx_count)
                    chk(rx_shift == exp_words[rx_count], "R8 received word",
                        {25'd0, rx_shift}, {25'd0, exp_words[rx_count]});
                rx_count++;
            end
        end
    end

    // One transfer; called just after a rising edge, returns just after the done cycle edge.
    task automatic run_xfer(input logic [W-1:0] w, input bit inj, input int inj_k, input logic [W-1:0] junk);
        start_i = 1'b1;
        word_i  = w;
        exp_words[tx_count] = w;
        tx_count++;
        @(posedge clk); #2;
        chk(busy_o === 1'b1, "R2 busy after start", {31'd0, busy_o}, 1);
        chk(done_o === 1'b0, "R6 done low at start", {31'd0, done_o}, 0);
        chk(enable_n_o === 1'b1, "R3 enable not before falling edge", {31'd0, enable_n_o}, 1);
        start_i = 1'b0;
        word_i  = junk;
        for (int k = 0; k < 2 * W; k++) begin
            if (inj && k == inj_k) start_i = 1'b1;
            @(posedge clk); #2;
            start_i = 1'b0;
            chk(enable_n_o === 1'b0, "R3 enable low during frame", {31'd0, enable_n_o}, 0);
            chk(sdata_o === exp_bit(w, k), "R4 bit slot", {31'd0, sdata_o}, {31'd0, exp_bit(w, k)});
            chk(busy_o === 1'b1, "R2 busy through frame", {31'd0, busy_o}, 1);
            if (inj && k >= inj_k)
                chk(sdata_o === exp_bit(w, k), "R7 start while busy ignored", {31'd0, sdata_o}, {31'd0, exp_bit(w, k)});
        end
        @(posedge clk); #2;
        chk(enable_n_o === 1'b1, "R5 enable released", {31'd0, enable_n_o}, 1);
        chk(sdata_o === 1'b0, "R5 data low after frame", {31'd0, sdata_o}, 0);
        chk(done_o === 1'b1, "R6 done pulse", {31'd0, done_o}, 1);
        chk(busy_o === 1'b0, "R6 busy low with done", {31'd0, busy_o}, 0);
    endtask

    task automatic idle_cycle;
        @(posedge clk); #2;
        chk(done_o === 1'b0, "R6 done one cycle", {31'd0, done_o}, 0);
        chk(busy_o === 1'b0 && enable_n_o === 1'b1 && sdata_o === 1'b0, "R1 idle outputs",
            {29'd0, busy_o, enable_n_o, sdata_o}, 32'h2);
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'h5EED);
        // Reset with a start held high: must be ignored (R1).
        start_i = 1'b1;
        word_i  = 7'h2A;
        repeat (4) @(posedge clk);
        #2;
        chk(enable_n_o === 1'b1 && sdata_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
            "R1 reset state", {28'd0, enable_n_o, sdata_o, busy_o, done_o}, 32'h8);
        start_i = 1'b0;
        rst_n   = 1'b1;
        idle_cycle();
        idle_cycle();

        // Directed corners.
        run_xfer(7'h7F, 1'b0, 0, 7'h00);
        idle_cycle();
        run_xfer(7'h00, 1'b1, 0, 7'h7F);      // R7 start at first tick
        idle_cycle();
        run_xfer(7'h55, 1'b1, 2 * W - 1, 7'h2A); // R7 start at last tick
        run_xfer(7'h40, 1'b0, 0, 7'h3F);      // R9 back to back
        run_xfer(7'h01, 1'b0, 0, 7'h7E);      // R9 back to back
        idle_cycle();

        // Seeded random transfers; gap 0 exercises R9.
        for (int n = 0; n < 40; n++) begin
            logic [W-1:0] w, junk;
            int gap;
            w    = W'($urandom % (1 << W));
            junk = W'($urandom % (1 << W));
            gap  = $urandom % 4;
            run_xfer(w, ($urandom % 3) == 0, $urandom % (2 * W), junk);
            for (int g = 0; g < gap; g++) idle_cycle();
        end

        repeat (6) idle_cycle();
        chk(rx_count == tx_count, "R8 one transfer per start", rx_count, tx_count);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule